// File: doc/BRIEF.md
# Quadrature Position Decoder with Revolution Split

This block turns the two phase signals of a rotary encoder, plus an index pulse, into a 16-bit position word. A run-time setting divides the word at a movable boundary. The low part is an angular counter between 9 and 16 bits wide. The bits above it count whole turns, up or down. Each of the three inputs is taken either from a device pin or from an internal event line. A pin can have its polarity reversed, and the two phase signals can be exchanged before decoding.

The decoder counts either every edge of both phases (4x) or only the edges of phase A (2x). The phase relationship gives the direction. Optionally, a period value sets the top of the angular range in place of the field's natural maximum.

All configuration is captured only while `enable` is low. While the block is enabled, the configuration inputs have no effect, and the position is held at zero whenever the block is disabled. There is no data stream here: every input and output is a plain level, so there is no back-pressure.

Top module: `qdec_rev_counter`

## Requirements
- R1: While `enable` is low, and after reset, `position` reads 0; it returns to 0 one cycle after `enable` falls.
- R2: The angular field is `position[W-1:0]` with W = `ang_len` + 9; bits above W form the revolution field.
- R3: An up step with the angular field at its top value reloads the angular field to 0 and adds one to the revolution field.
- R4: A down step with the angular field at 0 loads it with its top value and subtracts one from the revolution field (which is modulo its width).
- R5: With `ang_len` = 7 the whole word is angular: an up step from 0xFFFF gives 0, and a down step from 0 gives 0xFFFF (or the period when enabled).
- R6: With `dec_conf` other than 2 (4x), each single-phase change moves the count by one. The (A,B) sequence 00→10→11→01→00, where phase A leads, counts up, and the reverse sequence counts down. With inputs still, the count does not move. A phase input change reaches `position` within three clock cycles.
- R7: With `dec_conf` = 2 (2x), only changes of phase A move the count; a change of B alone leaves it unchanged.
- R8: A transition in which both phases change in the same cycle leaves the count unchanged.
- R9: Input i (0 = A, 1 = B, 2 = index) comes from `pin_in[i]` when `pin_sel[i]` = 1 and from `evt_in[i]` when it is 0. `pin_inv[i]` inverts a pin-sourced input and has no effect on an event-sourced one.
- R10: With `swap_ab` = 1, signals 0 and 1 exchange sources after selection and inversion, which reverses the counting direction of a given input sequence.
- R11: With `per_en` = 1, the top value of the angular field is `period` masked to W bits, instead of all ones.
- R12: Changes to `pin_sel`, `pin_inv`, `swap_ab`, `dec_conf`, `per_en`, `period` and `ang_len` while `enable` is high have no effect until the block is next disabled.
- R13: A rising edge of the index input clears the angular field and keeps the revolution field, and takes priority over a phase step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run; low clears the count and opens the configuration |
| pin_in | input | 3 | Pin inputs {index, B, A} |
| evt_in | input | 3 | Event-line inputs {index, B, A} |
| pin_sel | input | 3 | Per-input source select, 1 = pin |
| pin_inv | input | 3 | Per-input pin polarity inversion |
| swap_ab | input | 1 | Exchange signal 0 and signal 1 |
| dec_conf | input | 3 | Decoding: 2 = 2x, otherwise 4x |
| per_en | input | 1 | Use `period` as the angular top value |
| period | input | 16 | Angular period value |
| ang_len | input | 3 | Angular width minus 9 |
| position | output | 16 | Revolution and angular count |

## Verification
A wrong decoder or input-path state shows at `position` as a count off by one or moving the wrong way. It appears within three cycles of the phase edge that caused it. A wrong boundary or top value stays hidden until the angular field wraps. For that reason the bench drives every angular width through a wrap, using a short period, and sweeps the full 9-bit range step by step. A configuration that leaks while the block is enabled shows only at the next wrap or direction check after the change, so the bench changes inputs while enabled and then checks at exactly those points.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int QDEC_NIN   = 3;   // A, B, index
  localparam int QDEC_CW    = 16;
  localparam int QDEC_ASW   = 3;
  localparam int QDEC_BASE  = 9;
  localparam logic [2:0] QDEC_CONF_X2 = 3'd2;

  typedef struct packed {
    logic [QDEC_NIN-1:0]  sel;
    logic [QDEC_NIN-1:0]  inv;
    logic                 swap;
    logic [2:0]           conf;
    logic                 per_en;
    logic [QDEC_CW-1:0]   period;
    logic [QDEC_ASW-1:0]  ang;
  } qdec_cfg_t;
endpackage

// File: rtl/qdec_input_cond.sv
module qdec_input_cond #(
  parameter int NIN    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] pin_in,
  input  logic [NIN-1:0] evt_in,
  input  logic [NIN-1:0] sel,
  input  logic [NIN-1:0] inv,
  input  logic           swap,
  output logic [NIN-1:0] sync_out
);
  logic [NIN-1:0] src, routed;
  logic [STAGES-1:0][NIN-1:0] chain;

  for (genvar i = 0; i < NIN; i++) begin : g_src
    assign src[i] = sel[i] ? (pin_in[i] ^ inv[i]) : evt_in[i];
  end

  always_comb begin
    routed = src;
    if (swap) begin
      routed[0] = src[1];
      routed[1] = src[0];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= (s == 0) ? routed : chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       x2_mode,
  input  logic [2:0] cur,      // {index, B, A}
  output logic [2:0] prev,
  output logic       step,
  output logic       up,
  output logic       idx_rise
);
  logic a_chg, b_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur;
  end

  always_comb begin
    a_chg    = cur[0] ^ prev[0];
    b_chg    = cur[1] ^ prev[1];
    idx_rise = cur[2] & ~prev[2];
    step     = x2_mode ? (a_chg & ~b_chg) : (a_chg ^ b_chg);
    up       = a_chg ? (cur[0] ^ cur[1]) : ~(cur[0] ^ cur[1]);
  end
endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter #(
  parameter int CW   = 16,
  parameter int ASW  = 3,
  parameter int BASE = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  input  logic           up,
  input  logic           idx_rise,
  input  logic [ASW-1:0] ang_sel,
  input  logic           per_en,
  input  logic [CW-1:0]  period,
  output logic [CW-1:0]  count
);
  localparam int WW = $clog2(CW + 1);

  logic [WW-1:0] w;
  logic [CW-1:0] mask, ang, rev, lim, one_rev, nxt;

  always_comb begin
    w       = WW'(BASE) + WW'(ang_sel);
    mask    = ~({CW{1'b1}} << w);
    ang     = count & mask;
    rev     = count & ~mask;
    lim     = per_en ? (period & mask) : mask;
    one_rev = mask + CW'(1);
    nxt     = count;
    if (idx_rise) begin
      nxt = rev;
    end else if (step) begin
      if (up) nxt = (ang >= lim) ? (rev + one_rev) : (rev | (ang + CW'(1)));
      else    nxt = (ang == '0)  ? ((rev - one_rev) | lim) : (rev | (ang - CW'(1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= nxt;
  end
endmodule

// File: rtl/qdec_rev_counter.sv
module qdec_rev_counter
  import qdec_pkg::*;
#(
  parameter int CW     = QDEC_CW,
  parameter int ASW    = QDEC_ASW,
  parameter int BASE   = QDEC_BASE,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [2:0]    pin_in,
  input  logic [2:0]    evt_in,
  input  logic [2:0]    pin_sel,
  input  logic [2:0]    pin_inv,
  input  logic          swap_ab,
  input  logic [2:0]    dec_conf,
  input  logic          per_en,
  input  logic [CW-1:0] period,
  input  logic [ASW-1:0] ang_len,
  output logic [CW-1:0] position
);
  logic [2:0]    cfg_sel, cfg_inv, cfg_conf;
  logic          cfg_swap, cfg_per_en;
  logic [CW-1:0] cfg_period;
  logic [ASW-1:0] cfg_ang;
  logic [2:0]    ph_cur, ph_prev;
  logic          step, up, idx_rise;

  // configuration is open only while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel <= '0; cfg_inv <= '0; cfg_conf <= '0; cfg_swap <= 1'b0;
      cfg_per_en <= 1'b0; cfg_period <= '0; cfg_ang <= '0;
    end else if (!enable) begin
      cfg_sel <= pin_sel; cfg_inv <= pin_inv; cfg_conf <= dec_conf;
      cfg_swap <= swap_ab; cfg_per_en <= per_en; cfg_period <= period;
      cfg_ang <= ang_len;
    end
  end

  qdec_input_cond #(.NIN(3), .STAGES(STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .evt_in(evt_in),
    .sel(cfg_sel), .inv(cfg_inv), .swap(cfg_swap), .sync_out(ph_cur)
  );

  qdec_step_decode u_dec (
    .clk(clk), .rst_n(rst_n), .x2_mode(cfg_conf == QDEC_CONF_X2),
    .cur(ph_cur), .prev(ph_prev), .step(step), .up(up), .idx_rise(idx_rise)
  );

  qdec_pos_counter #(.CW(CW), .ASW(ASW), .BASE(BASE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .step(step), .up(up),
    .idx_rise(idx_rise), .ang_sel(cfg_ang), .per_en(cfg_per_en),
    .period(cfg_period), .count(position)
  );
endmodule

// File: rtl/qdec_rev_counter_chk.sv
module qdec_rev_counter_chk #(
  parameter int CW   = 16,
  parameter int ASW  = 3,
  parameter int BASE = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic [CW-1:0]  position,
  input logic [2:0]     ph_cur,
  input logic [2:0]     ph_prev,
  input logic [ASW-1:0] cfg_ang,
  input logic           cfg_per_en,
  input logic [CW-1:0]  cfg_period,
  input logic [2:0]     cfg_sel,
  input logic           cfg_swap
);
  localparam int WW = $clog2(CW + 1);
  logic [WW-1:0] w_chk;
  logic [CW-1:0] m_chk;
  assign w_chk = WW'(BASE) + WW'(cfg_ang);
  assign m_chk = ~({CW{1'b1}} << w_chk);

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> position == '0);  // R1
  AST_STILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph_cur == ph_prev) |=> $stable(position));  // R6
  AST_ILLEGAL_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (ph_cur[1:0] ^ ph_prev[1:0]) == 2'b11 && !(ph_cur[2] && !ph_prev[2]))
      |=> $stable(position));  // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(cfg_ang) && $stable(cfg_per_en) &&
      $stable(cfg_period) && $stable(cfg_sel) && $stable(cfg_swap)));  // R12
  AST_ANG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cfg_per_en) |-> ((position & m_chk) <= (cfg_period & m_chk)));  // R11
endmodule

bind qdec_rev_counter qdec_rev_counter_chk #(.CW(CW), .ASW(ASW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .position(position),
  .ph_cur(ph_cur), .ph_prev(ph_prev), .cfg_ang(cfg_ang),
  .cfg_per_en(cfg_per_en), .cfg_period(cfg_period), .cfg_sel(cfg_sel),
  .cfg_swap(cfg_swap)
);

// File: tb/qdec_rev_counter_tb.sv
module qdec_rev_counter_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [2:0]  pin_in = '0, evt_in = '0, pin_sel = 3'b111, pin_inv = '0, dec_conf = '0;
  logic        swap_ab = 1'b0, per_en = 1'b0;
  logic [15:0] period = '0;
  logic [2:0]  ang_len = '0;
  logic [15:0] position;

  int n_chk = 0, n_fail = 0;
  int g = 0;          // gray state index
  bit idx = 1'b0;
  bit use_evt = 1'b0;
  logic [15:0] exp_c = '0;

  always #(CLK_P/2) clk = ~clk;

  qdec_rev_counter u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pin_in(pin_in), .evt_in(evt_in),
    .pin_sel(pin_sel), .pin_inv(pin_inv), .swap_ab(swap_ab), .dec_conf(dec_conf),
    .per_en(per_en), .period(period), .ang_len(ang_len), .position(position)
  );

  // (A,B) for state k: 00,10,11,01
  function automatic logic [1:0] ba_of(int k);
    int q = k & 3;
    return {logic'(q >= 2), logic'(q == 1 || q == 2)};
  endfunction

  function automatic logic [15:0] model(logic [15:0] c, bit upd, int s, bit pe, logic [15:0] per);
    int w = s + 9;
    int m = (w >= 16) ? 32'hFFFF : ((1 << w) - 1);
    int a = c & m;
    int r = (w >= 16) ? 0 : (c >> w);
    int top = pe ? (per & m) : m;
    if (upd) begin
      if (a >= top) begin a = 0; r = r + 1; end else a = a + 1;
    end else begin
      if (a == 0) begin a = top; r = r - 1; end else a = a - 1;
    end
    return (w >= 16) ? 16'(a) : 16'((r << w) | a);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: position=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive();
    @(negedge clk);
    if (use_evt) begin
      evt_in = {idx, ba_of(g)};
      pin_in = {1'b0, ba_of(-g)};
    end else begin
      pin_in = {idx, ba_of(g)};
      evt_in = {1'b0, ba_of(-g)};
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic move(int d);
    g = (g + d) & 3;
    drive();
  endtask

  task automatic reconfig(int s, bit pe, logic [15:0] per, logic [2:0] conf);
    @(negedge clk);
    enable = 1'b0;
    ang_len = 3'(s); per_en = pe; period = per; dec_conf = conf;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    exp_c = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: position=%h expected=done", position);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", position, 16'h0);
    rst_n = 1'b1;
    drive();
    check("R1 disabled", position, 16'h0);

    // R2 R3: full 9-bit sweep up across a wrap
    reconfig(0, 1'b0, 16'h0, 3'd0);
    for (int i = 0; i < 514; i++) begin
      move(1);
      exp_c = model(exp_c, 1'b1, 0, 1'b0, 16'h0);
      check("R2 R3 sweep up", position, exp_c);
    end
    // R4: back down across the wrap
    for (int i = 0; i < 4; i++) begin
      move(-1);
      exp_c = model(exp_c, 1'b0, 0, 1'b0, 16'h0);
      check("R4 sweep down", position, exp_c);
    end

    // R2 R11 R5: each width wraps at period 3, up and down
    for (int s = 0; s < 8; s++) begin
      reconfig(s, 1'b1, 16'h0003, 3'd0);
      for (int i = 0; i < 4; i++) begin
        move(1);
        exp_c = model(exp_c, 1'b1, s, 1'b1, 16'h0003);
      end
      check("R2 R11 period wrap up", position, (s == 7) ? 16'h0 : 16'(1 << (s + 9)));
      for (int i = 0; i < 6; i++) begin
        move(-1);
        exp_c = model(exp_c, 1'b0, s, 1'b1, 16'h0003);
        check("R4 R11 period down", position, exp_c);
      end
    end
    // R5: full width without period
    reconfig(7, 1'b0, 16'h0, 3'd0);
    move(-1);
    check("R5 full width down", position, 16'hFFFF);
    move(1);
    check("R5 full width up", position, 16'h0000);

    // R6 R7: 2x counts only A edges
    reconfig(0, 1'b0, 16'h0, 3'd2);
    for (int i = 0; i < 4; i++) begin
      move(1);
      if ((g & 1) == 1 || g == 2) ; // no-op
      check("R7 2x up", position, 16'((i + 1 + ((g == 1 || g == 3) ? 1 : 0)) / 2 + ((g == 1 || g == 3) ? 0 : 0)));
    end
    check("R7 2x four states", position, 16'd2);

    // R8: both phases jump
    reconfig(0, 1'b0, 16'h0, 3'd0);
    move(1);
    move(2);
    check("R8 illegal jump", position, 16'd1);
    move(1);
    check("R6 resume after illegal", position, 16'd2);
    move(-1);
    check("R6 down", position, 16'd1);

    // R13: index clears angular, keeps revolutions
    reconfig(0, 1'b1, 16'h0001, 3'd0);
    for (int i = 0; i < 5; i++) move(1);     // ang=1, rev=2
    check("R13 before index", position, 16'h0401);
    idx = 1'b1; drive();
    check("R13 index rise", position, 16'h0400);
    idx = 1'b0; drive();
    check("R13 index fall no effect", position, 16'h0400);

    // R12: change config while enabled, no effect
    reconfig(0, 1'b0, 16'h0, 3'd0);
    per_en = 1'b1; period = 16'h0001; ang_len = 3'd7; dec_conf = 3'd2;
    for (int i = 0; i < 3; i++) move(1);
    check("R12 frozen while enabled", position, 16'd3);
    for (int i = 0; i < 4; i++) move(-1);
    check("R12 frozen down wrap", position, 16'hFFFF);
    ang_len = 3'd0; per_en = 1'b0; dec_conf = 3'd0;

    // R10: swap reverses direction
    swap_ab = 1'b1;
    reconfig(0, 1'b0, 16'h0, 3'd0);
    move(1);
    check("R10 swap reverses", position, 16'hFFFF);
    move(-1);
    check("R10 swap back", position, 16'h0000);
    swap_ab = 1'b0;

    // R9: inverting B on a pin reverses direction
    pin_inv = 3'b010;
    reconfig(0, 1'b0, 16'h0, 3'd0);
    move(1);
    check("R9 pin invert B", position, 16'hFFFF);
    // R9: event source ignores pin and invert
    pin_sel = 3'b100; use_evt = 1'b1; pin_inv = 3'b011;
    reconfig(0, 1'b0, 16'h0, 3'd0);
    move(1); move(1);
    check("R9 event source", position, 16'd2);
    move(-1);
    check("R9 event source down", position, 16'd1);

    // R1: disable clears
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R1 disable clears", position, 16'h0);
    move(1);
    check("R1 held while disabled", position, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule